// File: doc/BRIEF.md
# Storage Display Erase Sequence Timer

This block runs the timed erase and preparation cycle of a bistable storage display as a set of logic-level enables. A release of the erase request input sets the time origin. From that point a millisecond counter, advanced by an external tick strobe, opens and closes a set of overlapping windows. These windows cover the first erase, the flood-gun and collimator-1 boosts, the collimator-3 raise, the second erase, the front-mesh set level, a low-duty preparatory pulse train for the fast mesh, and the unblanking of the time-base.

The fast-mode input gates every step after the boost window. Some of those steps take the fast-mode level at the instant they begin and then hold it, like a flip-flop clocked at that moment. The others follow the live level. The sweep-start input marks the transfer point and ends the front-mesh set level and the pulse train. Another release of the erase request restarts the timeline from zero at any time. Analog levels and drive stages sit outside the block.

Top module: `est_erase_seq`

## Requirements
- R1: The timeline starts only on a high-to-low transition of `erase_req`. After two synchroniser stages and one edge-detect stage, `first_erase_o` goes high on the third rising clock edge after `erase_req` is first sampled low. A rising transition starts nothing.
- R2: `first_erase_o` is high while the elapsed time is below T_FIRST ms (default 100) and low afterwards.
- R3: `flood_boost_o` and `coll1_boost_o` are both high while the elapsed time is below T_BOOST ms (default 600) and low afterwards.
- R4: When the elapsed time reaches T_BOOST, `coll3_raise_o` takes the `fast_mode` level of that instant. It keeps that value until the timeline restarts or reset.
- R5: `second_erase_o` is high while the elapsed time is at least T_BOOST and below T_SECOND_END ms (default 1500), and only while `fast_mode` is currently high.
- R6: When the elapsed time reaches T_SECOND_END, `front_mesh_set_o` takes the `fast_mode` level of that instant. It is cleared on the clock after `sweep_start` is sampled high. A clear and a set on the same edge resolve to clear.
- R7: When the elapsed time reaches T_MESH ms (default 900), the pulse train is armed if `fast_mode` is high at that instant. While armed, `mesh_pulse_o` repeats with a period of BURST_PERIOD ticks and is high for the first BURST_HIGH ticks of each period, starting high on the arming clock. `sweep_start` disarms it.
- R8: `unblank_o` is high once the elapsed time reaches T_UNBLANK ms (default 1600), and only while `fast_mode` is currently high.
- R9: With `fast_mode` low throughout, only `first_erase_o`, `flood_boost_o` and `coll1_boost_o` ever go high.
- R10: A new release during a running timeline restarts it from zero. `coll3_raise_o`, `front_mesh_set_o`, `mesh_pulse_o` and the armed state are cleared, and `first_erase_o` is high again.
- R11: Elapsed time advances only on clocks with `tick` high. One millisecond is TICKS_PER_MS ticks.
- R12: While reset is asserted, and after it until the first release, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Time-base strobe, one clock wide per tick |
| erase_req | input | 1 | Erase request, asynchronous; release starts the timeline |
| fast_mode | input | 1 | Fast-mode select |
| sweep_start | input | 1 | Start of sweep (transfer point), synchronous pulse |
| first_erase_o | output | 1 | First erase enable |
| flood_boost_o | output | 1 | Flood-gun boost enable |
| coll1_boost_o | output | 1 | Collimator-1 boost enable |
| coll3_raise_o | output | 1 | Collimator-3 raise enable |
| second_erase_o | output | 1 | Second erase enable |
| front_mesh_set_o | output | 1 | Front-mesh set enable |
| mesh_pulse_o | output | 1 | Fast-mesh preparatory pulse train |
| unblank_o | output | 1 | Time-base unblank enable |

## Verification
The bench checks every output on every clock against a tick-accurate timeline model, so an off-by-one boundary shows up as a one-clock mismatch at that edge. Examples are a window that closes at 599 ms, or a pulse train that starts low or runs one tick long. `fast_mode` is toggled on both sides of the 600 ms point to separate the levels taken at one instant from the live levels. A design that gated collimator-3 by the live level, or the second erase by a stored level, fails there. Other runs miss a third of the ticks, sweep in the middle of the pulse train, and re-release the request in the middle of the timeline. These catch a design that counts clocks instead of ticks, keeps flags across a restart, or lets a late set override the sweep clear.

// File: rtl/est_pkg.sv
package est_pkg;

  typedef struct packed {
    logic first_erase;
    logic flood_boost;
    logic coll1_boost;
    logic coll3_raise;
    logic second_erase;
    logic front_mesh_set;
    logic mesh_pulse;
    logic unblank;
  } est_ctl_t;

  function automatic int est_width(input int max_value);
    return (max_value > 1) ? $clog2(max_value + 1) : 1;
  endfunction

endpackage

// File: rtl/est_release_sync.sv
module est_release_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic erase_req,
  output logic release_o
);

  logic [2:0] stage_q;
  logic [2:0] stage_n;

  always_comb begin
    stage_n = {stage_q[1:0], erase_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_n;
    end
  end

  // stage_q[1] is the synchronised level, stage_q[2] its previous value
  assign release_o = stage_q[2] & ~stage_q[1];

endmodule

// File: rtl/est_ms_timer.sv
module est_ms_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int MS_MAX       = 1600,
  parameter int MSW          = est_pkg::est_width(MS_MAX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           restart,
  output logic           running_o,
  output logic [MSW-1:0] ms_o,
  output logic           ms_step_o
);

  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [TW-1:0]  TC_LAST = TW'(TICKS_PER_MS - 1);
  localparam logic [MSW-1:0] MS_SAT  = MSW'(MS_MAX);

  logic           run_q, run_n;
  logic [TW-1:0]  tc_q, tc_n;
  logic [MSW-1:0] ms_q, ms_n;
  logic           advance;

  assign advance   = !restart && tick && run_q && (ms_q != MS_SAT);
  assign ms_step_o = advance && (tc_q == TC_LAST);

  always_comb begin
    run_n = run_q;
    tc_n  = tc_q;
    ms_n  = ms_q;
    if (restart) begin
      run_n = 1'b1;
      tc_n  = '0;
      ms_n  = '0;
    end else if (advance) begin
      if (tc_q == TC_LAST) begin
        tc_n = '0;
        ms_n = ms_q + MSW'(1);
      end else begin
        tc_n = tc_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tc_q  <= '0;
      ms_q  <= '0;
    end else begin
      run_q <= run_n;
      tc_q  <= tc_n;
      ms_q  <= ms_n;
    end
  end

  assign running_o = run_q;
  assign ms_o      = ms_q;

endmodule

// File: rtl/est_burst_gen.sv
module est_burst_gen #(
  parameter int PERIOD = 6667,
  parameter int HIGH   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  output logic pulse_o
);

  localparam int PW = est_pkg::est_width(PERIOD - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(HIGH);

  logic [PW-1:0] phase_q, phase_n;

  always_comb begin
    phase_n = phase_q;
    if (!arm) begin
      phase_n = '0;
    end else if (tick) begin
      phase_n = (phase_q == PH_LAST) ? '0 : phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_n;
    end
  end

  assign pulse_o = arm && (phase_q < PH_HIGH);

endmodule

// File: rtl/est_erase_seq.sv
module est_erase_seq #(
  parameter int TICKS_PER_MS = 1000,
  parameter int T_FIRST      = 100,
  parameter int T_BOOST      = 600,
  parameter int T_MESH       = 900,
  parameter int T_SECOND_END = 1500,
  parameter int T_UNBLANK    = 1600,
  parameter int BURST_PERIOD = 6667,
  parameter int BURST_HIGH   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic erase_req,
  input  logic fast_mode,
  input  logic sweep_start,
  output logic first_erase_o,
  output logic flood_boost_o,
  output logic coll1_boost_o,
  output logic coll3_raise_o,
  output logic second_erase_o,
  output logic front_mesh_set_o,
  output logic mesh_pulse_o,
  output logic unblank_o
);

  import est_pkg::*;

  localparam int MSW = est_width(T_UNBLANK);
  localparam logic [MSW-1:0] MS_FIRST    = MSW'(T_FIRST);
  localparam logic [MSW-1:0] MS_BOOST    = MSW'(T_BOOST);
  localparam logic [MSW-1:0] MS_SEC_END  = MSW'(T_SECOND_END);
  localparam logic [MSW-1:0] MS_UNBLANK  = MSW'(T_UNBLANK);
  localparam logic [MSW-1:0] PRE_BOOST   = MSW'(T_BOOST - 1);
  localparam logic [MSW-1:0] PRE_MESH    = MSW'(T_MESH - 1);
  localparam logic [MSW-1:0] PRE_SEC_END = MSW'(T_SECOND_END - 1);

  logic           restart;
  logic           running;
  logic [MSW-1:0] ms;
  logic           ms_step;
  logic           burst_pulse;

  logic coll3_q, coll3_n;
  logic arm_q, arm_n;
  logic fset_q, fset_n;

  est_ctl_t ctl;

  est_release_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_req (erase_req),
    .release_o (restart)
  );

  est_ms_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .MS_MAX       (T_UNBLANK),
    .MSW          (MSW)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .restart   (restart),
    .running_o (running),
    .ms_o      (ms),
    .ms_step_o (ms_step)
  );

  est_burst_gen #(
    .PERIOD (BURST_PERIOD),
    .HIGH   (BURST_HIGH)
  ) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .arm     (arm_q),
    .pulse_o (burst_pulse)
  );

  // Flags that capture the fast-mode level at a window boundary
  always_comb begin
    coll3_n = coll3_q;
    arm_n   = arm_q;
    fset_n  = fset_q;
    if (restart) begin
      coll3_n = 1'b0;
      arm_n   = 1'b0;
      fset_n  = 1'b0;
    end else begin
      if (ms_step && (ms == PRE_BOOST))   coll3_n = fast_mode;
      if (ms_step && (ms == PRE_MESH))    arm_n   = fast_mode;
      if (ms_step && (ms == PRE_SEC_END)) fset_n  = fast_mode;
      if (sweep_start) begin
        arm_n  = 1'b0;
        fset_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll3_q <= 1'b0;
      arm_q   <= 1'b0;
      fset_q  <= 1'b0;
    end else begin
      coll3_q <= coll3_n;
      arm_q   <= arm_n;
      fset_q  <= fset_n;
    end
  end

  always_comb begin
    ctl.first_erase    = running && (ms < MS_FIRST);
    ctl.flood_boost    = running && (ms < MS_BOOST);
    ctl.coll1_boost    = running && (ms < MS_BOOST);
    ctl.coll3_raise    = coll3_q;
    ctl.second_erase   = running && fast_mode && (ms >= MS_BOOST) && (ms < MS_SEC_END);
    ctl.front_mesh_set = fset_q;
    ctl.mesh_pulse     = burst_pulse;
    ctl.unblank        = running && fast_mode && (ms >= MS_UNBLANK);
  end

  assign first_erase_o    = ctl.first_erase;
  assign flood_boost_o    = ctl.flood_boost;
  assign coll1_boost_o    = ctl.coll1_boost;
  assign coll3_raise_o    = ctl.coll3_raise;
  assign second_erase_o   = ctl.second_erase;
  assign front_mesh_set_o = ctl.front_mesh_set;
  assign mesh_pulse_o     = ctl.mesh_pulse;
  assign unblank_o        = ctl.unblank;

endmodule

// File: rtl/est_erase_seq_chk.sv
module est_erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic fast_mode,
  input logic sweep_start,
  input logic restart,
  input logic first_erase_o,
  input logic flood_boost_o,
  input logic coll1_boost_o,
  input logic coll3_raise_o,
  input logic second_erase_o,
  input logic front_mesh_set_o,
  input logic mesh_pulse_o,
  input logic unblank_o
);

  p_first_in_boost_r2: assert property (@(posedge clk) disable iff (!rst_n)
    first_erase_o |-> flood_boost_o);

  p_boost_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flood_boost_o == coll1_boost_o);

  p_coll3_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coll3_raise_o && !restart) |=> coll3_raise_o);

  p_second_after_boost_r5: assert property (@(posedge clk) disable iff (!rst_n)
    second_erase_o |-> (!flood_boost_o && fast_mode));

  p_sweep_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_start && !restart) |=> !front_mesh_set_o);

  p_sweep_stops_train_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_start && !restart) |=> !mesh_pulse_o);

  p_unblank_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unblank_o |-> (fast_mode && !second_erase_o));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (first_erase_o && !coll3_raise_o && !front_mesh_set_o && !mesh_pulse_o));

endmodule

bind est_erase_seq est_erase_seq_chk u_chk (.*);

// File: tb/est_erase_seq_tb.sv
module est_erase_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TPM = 3;
  localparam int TF  = 100;
  localparam int TB  = 600;
  localparam int TM  = 900;
  localparam int TS  = 1500;
  localparam int TU  = 1600;
  localparam int BP  = 7;
  localparam int BH  = 2;

  logic clk = 1'b0;
  logic rst_n, tick, erase_req, fast_mode, sweep_start;
  logic first_erase_o, flood_boost_o, coll1_boost_o, coll3_raise_o;
  logic second_erase_o, front_mesh_set_o, mesh_pulse_o, unblank_o;

  int n_checks = 0;
  int n_fail   = 0;

  // bench timeline model
  int t;
  bit c3_m, arm_m, fms_m;
  bit nofast_scn;

  always #(CLK_PERIOD/2) clk = ~clk;

  est_erase_seq #(
    .TICKS_PER_MS (TPM), .T_FIRST (TF), .T_BOOST (TB), .T_MESH (TM),
    .T_SECOND_END (TS), .T_UNBLANK (TU), .BURST_PERIOD (BP), .BURST_HIGH (BH)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .tick (tick), .erase_req (erase_req),
    .fast_mode (fast_mode), .sweep_start (sweep_start),
    .first_erase_o (first_erase_o), .flood_boost_o (flood_boost_o),
    .coll1_boost_o (coll1_boost_o), .coll3_raise_o (coll3_raise_o),
    .second_erase_o (second_erase_o), .front_mesh_set_o (front_mesh_set_o),
    .mesh_pulse_o (mesh_pulse_o), .unblank_o (unblank_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check_outputs(input string pre);
    bit e_se, e_ub, e_mp;
    e_se = fast_mode && (t >= TB*TPM) && (t < TS*TPM);
    e_ub = fast_mode && (t >= TU*TPM);
    e_mp = arm_m && (((t - TM*TPM) % BP) < BH);
    chk({pre, " R2 first_erase"},    first_erase_o,    t < TF*TPM);
    chk({pre, " R3 flood_boost"},    flood_boost_o,    t < TB*TPM);
    chk({pre, " R3 coll1_boost"},    coll1_boost_o,    t < TB*TPM);
    chk({pre, " R4 coll3_raise"},    coll3_raise_o,    c3_m);
    chk({pre, " R5 second_erase"},   second_erase_o,   e_se);
    chk({pre, " R6 front_mesh_set"}, front_mesh_set_o, fms_m);
    chk({pre, " R7 mesh_pulse"},     mesh_pulse_o,     e_mp);
    chk({pre, " R8 unblank"},        unblank_o,        e_ub);
    if (nofast_scn)
      chk({pre, " R9 no fast-only output"},
          coll3_raise_o | second_erase_o | front_mesh_set_o | mesh_pulse_o | unblank_o, 1'b0);
  endtask

  // model update for one clock edge with the given inputs (R11: time moves on ticks only)
  task automatic adv_model(input bit tk, input bit fs, input bit sw);
    if (tk) begin
      t++;
      if (t == TB*TPM) c3_m  = fs;
      if (t == TM*TPM) arm_m = fs;
      if (t == TS*TPM) fms_m = fs;
    end
    if (sw) begin
      arm_m = 1'b0;
      fms_m = 1'b0;
    end
  endtask

  // release, then check every clock up to edge kend after the timeline load
  task automatic run_seq(input string pre, input bit f0, input int flip_k,
                         input int ks, input int kend, input int tick_div,
                         input bit fresh, input bit is_restart);
    erase_req = 1'b1;
    repeat (4) @(negedge clk);
    if (fresh) chk({pre, " R1 rising edge starts nothing"}, first_erase_o, 1'b0);
    erase_req   = 1'b0;
    fast_mode   = f0;
    sweep_start = 1'b0;
    tick        = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (fresh) chk({pre, " R1 not yet started"}, first_erase_o, 1'b0);
    @(negedge clk);
    t = 0; c3_m = 0; arm_m = 0; fms_m = 0;
    if (fresh) chk({pre, " R1 started on third edge"}, first_erase_o, 1'b1);
    if (is_restart) begin
      chk({pre, " R10 coll3 cleared"}, coll3_raise_o, 1'b0);
      chk({pre, " R10 first erase again"}, first_erase_o, 1'b1);
    end
    for (int k = 0; k <= kend; k++) begin
      bit tk, fs, sw;
      check_outputs(pre);
      tk = (tick_div <= 1) || (((k + 1) % tick_div) != 0);
      fs = (flip_k >= 0 && (k + 1) >= flip_k) ? ~f0 : f0;
      sw = ((k + 1) == ks);
      tick = tk; fast_mode = fs; sweep_start = sw;
      @(negedge clk);
      adv_model(tk, fs, sw);
    end
    sweep_start = 1'b0;
    tick        = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; erase_req = 1'b0; fast_mode = 1'b1; sweep_start = 1'b0;
    t = 0; c3_m = 0; arm_m = 0; fms_m = 0; nofast_scn = 0;
    repeat (3) @(negedge clk);
    // R12: outputs low in reset and after release with no erase request
    chk("R12 in reset", first_erase_o | flood_boost_o | coll1_boost_o | coll3_raise_o |
        second_erase_o | front_mesh_set_o | mesh_pulse_o | unblank_o, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 idle after reset", first_erase_o | flood_boost_o | coll1_boost_o | coll3_raise_o |
        second_erase_o | front_mesh_set_o | mesh_pulse_o | unblank_o, 1'b0);

    // full fast timeline, sweep after unblank
    run_seq("fast", 1'b1, -1, 1700*TPM, 1750*TPM, 1, 1'b1, 1'b0);
    // R9: fast mode low throughout
    nofast_scn = 1;
    run_seq("nofast", 1'b0, -1, -1, 1650*TPM, 1, 1'b1, 1'b0);
    nofast_scn = 0;
    // R4/R5: fast raised after the boost boundary, collimator-3 stays low
    run_seq("fast_late", 1'b0, 700*TPM, 1620*TPM, 1650*TPM, 1, 1'b1, 1'b0);
    // R4/R5: fast dropped after the boost boundary, collimator-3 stays high
    run_seq("fast_drop", 1'b1, 650*TPM, -1, 1000*TPM, 1, 1'b1, 1'b0);
    // R11: one tick in three missing; R7 sweep inside the pulse train
    run_seq("R11 sparse_tick", 1'b1, -1, 5000, 7500, 3, 1'b1, 1'b0);
    // R10: restart in the middle of a running timeline
    run_seq("pre_restart", 1'b1, -1, -1, 700*TPM, 1, 1'b1, 1'b0);
    run_seq("restart", 1'b1, -1, -1, 200*TPM, 1, 1'b0, 1'b1);

    summary();
  end

endmodule